// File: doc/BRIEF.md
# Programmable-Priority DMA Request Arbiter

This block chooses which of up to twelve DMA channels may move data next. The channels come from two controllers: a first controller with seven channels and a second controller with five. Each channel presents a request line, an enable and a two-bit priority level that software sets. When the arbiter is idle, it compares every enabled, requesting channel and issues a registered one-hot grant to one winner. It also reports which controller and which channel number won.

The level decides first. If levels are equal, the first controller wins over the second. Within one controller, the lowest channel number wins. No rotation takes place, so the same inputs always give the same grant. A grant stays in place until the transfer-done input is raised. The arbiter then goes idle for one cycle and arbitrates again on the following clock edge.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant_a`, `grant_b`, `gnt_ctrl` and `gnt_chan` are zero and `gnt_valid` is low.
- R2: A channel with a higher level always wins over one with a lower level, whatever their channel numbers or controllers. Level encoding runs from 2'b11 (highest) down to 2'b00 (lowest).
- R3: Among requesting channels of equal level in the same controller, the lowest channel number is granted.
- R4: When channels of both controllers share the highest requesting level, a channel of the first controller is granted.
- R5: A channel whose enable bit is low is never granted, even when its request is high.
- R6: Once issued, a grant and its reported controller and channel stay unchanged until `xfer_done` is sampled high. This holds even if higher-level requests arrive in the meantime.
- R7: When `xfer_done` is sampled high during a grant, `gnt_valid` is low after that edge. A pending request is granted on the next edge.
- R8: When no enabled channel requests, all grant bits are zero and `gnt_valid` is low.
- R9: Bit i of `grant_a` or `grant_b` is channel i, and `lvl_a`/`lvl_b` bits [2i+1:2i] are the level of channel i. `gnt_ctrl` is 0 for the first controller and 1 for the second. `gnt_chan` is the zero-based channel number. The grant appears on the first clock edge after an eligible request is presented to an idle arbiter.
- R10: A requesting channel at the lowest level (2'b00, the default level) is granted when nothing higher requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_a | input | 7 | Request lines, first controller |
| en_a | input | 7 | Channel enables, first controller |
| lvl_a | input | 14 | Two-bit levels, first controller |
| req_b | input | 5 | Request lines, second controller |
| en_b | input | 5 | Channel enables, second controller |
| lvl_b | input | 10 | Two-bit levels, second controller |
| xfer_done | input | 1 | Granted transfer finished |
| grant_a | output | 7 | One-hot grant, first controller |
| grant_b | output | 5 | One-hot grant, second controller |
| gnt_valid | output | 1 | A grant is active |
| gnt_ctrl | output | 1 | Controller of winner |
| gnt_chan | output | 3 | Channel number of winner |

## Verification
The hardest case is a higher-level request arriving while a lower-level grant is held. That request must be ignored until the done pulse, and then win exactly one edge after the idle cycle. The stimulus first issues a level-0 grant and then raises a level-3 request on another channel. It keeps `xfer_done` low for several edges before pulsing it, with the new request still high. The cross-controller tie and the masked top-level channel are reached by placing equal or higher levels on channels that would win under a wrong order.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NA = 7,
  parameter int NB = 5,
  parameter int LW = 2,
  parameter int CW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NA-1:0]    req_a,
  input  logic [NA-1:0]    en_a,
  input  logic [NA*LW-1:0] lvl_a,
  input  logic [NB-1:0]    req_b,
  input  logic [NB-1:0]    en_b,
  input  logic [NB*LW-1:0] lvl_b,
  input  logic             xfer_done,
  output logic [NA-1:0]    grant_a,
  output logic [NB-1:0]    grant_b,
  output logic             gnt_valid,
  output logic             gnt_ctrl,
  output logic [CW-1:0]    gnt_chan
);
  localparam int NT = NA + NB;
  localparam int IW = $clog2(NT);

  logic [NT-1:0]    elig;
  logic [NT*LW-1:0] lvl_all;
  logic [LW-1:0]    best;
  logic             any_req;
  logic [IW-1:0]    pick;
  logic [NT-1:0]    gnt_q;
  logic [IW-1:0]    idx_q;

  assign elig    = {req_b & en_b, req_a & en_a};
  assign lvl_all = {lvl_b, lvl_a};

  always_comb begin
    best    = '0;
    any_req = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (elig[i] && (!any_req || lvl_all[i*LW +: LW] > best)) begin
        best    = lvl_all[i*LW +: LW];
        any_req = 1'b1;
      end
    end
  end

  always_comb begin
    pick = '0;
    for (int i = NT-1; i >= 0; i--) begin
      if (elig[i] && lvl_all[i*LW +: LW] == best) pick = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= '0;
      idx_q <= '0;
    end else if (gnt_valid) begin
      if (xfer_done) gnt_q <= '0;
    end else if (any_req) begin
      gnt_q <= NT'(1) << pick;
      idx_q <= pick;
    end
  end

  assign gnt_valid = |gnt_q;
  assign grant_a   = gnt_q[NA-1:0];
  assign grant_b   = gnt_q[NT-1:NA];
  assign gnt_ctrl  = gnt_valid && (idx_q >= IW'(NA));
  assign gnt_chan  = !gnt_valid ? '0 :
                     gnt_ctrl   ? CW'(idx_q - IW'(NA)) : CW'(idx_q);
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NA = 7,
  parameter int NB = 5,
  parameter int LW = 2,
  parameter int CW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NA-1:0]    req_a,
  input logic [NA-1:0]    en_a,
  input logic [NB-1:0]    req_b,
  input logic [NB-1:0]    en_b,
  input logic             xfer_done,
  input logic [NA-1:0]    grant_a,
  input logic [NB-1:0]    grant_b,
  input logic             gnt_valid,
  input logic             gnt_ctrl,
  input logic [CW-1:0]    gnt_chan
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_b, grant_a})); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> ({grant_b, grant_a} == '0 && gnt_chan == '0)); // R8
  AST_CTRL_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_ctrl == (|grant_b))); // R9
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !xfer_done) |=> (gnt_valid && $stable({grant_b, grant_a}) && $stable(gnt_chan))); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && xfer_done) |=> !gnt_valid); // R7
  AST_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> (|({grant_b, grant_a} & $past({req_b & en_b, req_a & en_a})))); // R5
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NA(NA), .NB(NB), .LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_a(req_a), .en_a(en_a), .req_b(req_b), .en_b(en_b),
  .xfer_done(xfer_done), .grant_a(grant_a), .grant_b(grant_b), .gnt_valid(gnt_valid),
  .gnt_ctrl(gnt_ctrl), .gnt_chan(gnt_chan)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, xfer_done = 1'b0;
  logic [6:0] req_a = '0, en_a = '0, grant_a;
  logic [4:0] req_b = '0, en_b = '0, grant_b;
  logic [13:0] lvl_a = '0;
  logic [9:0] lvl_b = '0;
  logic gnt_valid, gnt_ctrl;
  logic [2:0] gnt_chan;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_arbiter u_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .en_a(en_a), .lvl_a(lvl_a),
    .req_b(req_b), .en_b(en_b), .lvl_b(lvl_b), .xfer_done(xfer_done),
    .grant_a(grant_a), .grant_b(grant_b), .gnt_valid(gnt_valid),
    .gnt_ctrl(gnt_ctrl), .gnt_chan(gnt_chan)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear();
    req_a = '0; en_a = '0; lvl_a = '0; req_b = '0; en_b = '0; lvl_b = '0;
  endtask

  task automatic ch_a(int i, logic [1:0] l, bit en = 1);
    req_a[i] = 1'b1; en_a[i] = en; lvl_a[2*i +: 2] = l;
  endtask

  task automatic ch_b(int i, logic [1:0] l, bit en = 1);
    req_b[i] = 1'b1; en_b[i] = en; lvl_b[2*i +: 2] = l;
  endtask

  task automatic expect_gnt(string r, bit v, bit c, int ch);
    logic [6:0] ea; logic [4:0] eb; logic [2:0] ec;
    ea = (v && !c) ? 7'(1 << ch) : '0;
    eb = (v && c)  ? 5'(1 << ch) : '0;
    ec = v ? 3'(ch) : '0;
    checks++;
    if (gnt_valid !== v || grant_a !== ea || grant_b !== eb ||
        gnt_ctrl !== (v && c) || gnt_chan !== ec) begin
      errors++;
      $display("FAIL %s: got v=%b a=%b b=%b ctrl=%b chan=%0d, expected v=%b a=%b b=%b ctrl=%b chan=%0d",
               r, gnt_valid, grant_a, grant_b, gnt_ctrl, gnt_chan, v, ea, eb, v && c, ec);
    end
  endtask

  task automatic release_gnt(string r);
    clear(); xfer_done = 1'b1; step(); xfer_done = 1'b0;
    expect_gnt(r, 0, 0, 0);
    step();
  endtask

  task automatic t_reset();
    expect_gnt("R1 reset", 0, 0, 0);
  endtask

  task automatic t_level();
    ch_a(0, 2'b01); ch_a(6, 2'b11); step();
    expect_gnt("R2 level beats channel", 1, 0, 6);
    release_gnt("R7 release");
    ch_a(0, 2'b10); ch_b(4, 2'b11); step();
    expect_gnt("R2 level beats controller", 1, 1, 4);
    release_gnt("R7 release");
  endtask

  task automatic t_same_ctrl();
    ch_a(5, 2'b10); ch_a(2, 2'b10); step();
    expect_gnt("R3 lowest channel A", 1, 0, 2);
    release_gnt("R7 release");
    ch_b(3, 2'b01); ch_b(1, 2'b01); step();
    expect_gnt("R3 lowest channel B / R9 numbering", 1, 1, 1);
    release_gnt("R7 release");
  endtask

  task automatic t_cross();
    ch_a(5, 2'b01); ch_b(0, 2'b01); step();
    expect_gnt("R4 first controller wins tie", 1, 0, 5);
    release_gnt("R7 release");
  endtask

  task automatic t_disable();
    ch_a(0, 2'b11, 0); ch_b(0, 2'b11, 0); ch_a(3, 2'b00); step();
    expect_gnt("R5 disabled masked", 1, 0, 3);
    release_gnt("R7 release");
    ch_a(1, 2'b11, 0); step();
    expect_gnt("R5 only disabled requester", 0, 0, 0);
    clear(); step();
  endtask

  task automatic t_idle();
    step(); step();
    expect_gnt("R8 no requests", 0, 0, 0);
  endtask

  task automatic t_low();
    ch_b(2, 2'b00); step();
    expect_gnt("R10 lowest level granted", 1, 1, 2);
    release_gnt("R7 release");
  endtask

  task automatic t_hold();
    ch_a(4, 2'b00); step();
    expect_gnt("R9 grant one edge after request", 1, 0, 4);
    ch_a(0, 2'b11); step(); step();
    expect_gnt("R6 grant held", 1, 0, 4);
    req_a[4] = 1'b0; step();
    expect_gnt("R6 held after request drops", 1, 0, 4);
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
    expect_gnt("R7 idle after done", 0, 0, 0);
    step();
    expect_gnt("R7 rearbitrate next edge", 1, 0, 0);
    release_gnt("R7 release");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1; step();
    t_idle();
    t_level();
    t_same_ctrl();
    t_cross();
    t_disable();
    t_low();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule